// File: doc/BRIEF.md
# Fault-Injecting Serial Character Transmitter

This block drives an asynchronous serial line so that a receiver under test can be exercised with both clean and deliberately corrupted traffic. Each character is framed with a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a stop period. Each bit lasts 16 ticks of an external oversampling tick input. Between characters the line rests high.

Configuration inputs select the character length, one of five parity modes and a short or long stop period. They also enable fault injection:
- a parity bit inverted from its correct value;
- a stop period driven low;
- a single one-clock inversion of the line at a programmed clock offset from a start edge;
- a low break period appended to every character.

A request hands over either a supplied byte or a choice of pseudo-random data, together with a character count for bursts. A one-clock done pulse marks the end of the final character.

Top module: `fi_uart_tx`

## Requirements
- R1: After reset the line is high, `busy` is 0 and `req_ready` is 1.
- R2: A character is sent as a start bit held low, then data bits least significant first, each for 16 baud ticks. The number of data bits comes from `cfg_len`: values from 5 to 8 are used directly, a value below 5 acts as 5 and a value above 8 acts as 8.
- R3: `cfg_par` is one-hot. Its bits select the parity mode as follows:
  - bit0: no parity bit;
  - bit1: odd parity, so the data bits plus the parity bit hold an odd number of ones;
  - bit2: even parity;
  - bit3: the parity bit is always 1;
  - bit4: the parity bit is always 0.

  When parity is selected, the parity bit follows the last data bit and lasts 16 ticks.
- R4: With `cfg_stop2` at 0, the stop period is high for 16 ticks. With `cfg_stop2` at 1, it lasts 24 ticks for a 5-bit character and 32 ticks for any other length.
- R5: With `cfg_bad_par` set, the parity bit is the inverse of its correct value. When no parity bit is selected, this input has no effect.
- R6: With `cfg_bad_stop` set, the line is low for the whole stop period.
- R7: A pulse on `glitch_wr` with a nonzero `glitch_clks` value N arms a one-shot glitch. After the next start edge, the line is inverted for exactly the one clock that begins N clocks after that edge, and the glitch then disarms. A write with N equal to 0 disarms it.
- R8: With `cfg_brk_en` set and `cfg_brk_len` equal to B, the line is held low for B×16 ticks after the stop period. When B is 0, no break is sent.
- R9: A request is accepted when `req_valid` and `req_ready` are both high, and `req_ready` stays low while `busy` is high. The request sends `req_count` characters, with a count of 0 treated as 1. Supplied data repeats `req_char` for every character. The first start edge comes one clock after the accepting edge, and each later start edge follows the previous character's end after one high clock.
- R10: With `req_rnd` set, each character takes the low data-length bits of a 16-bit shift register. The register is seeded to 0xACE1 at reset. After every random character it steps to {q[14:0], q[15]^q[13]^q[12]^q[10]}.
- R11: `done` pulses for one clock, and `busy` falls, in the clock where the line returns high after the final character. No pulse occurs after earlier characters of a burst.
- R12: The configuration is sampled at each character's start edge, so a change made mid-character first applies to the next character.
- R13: Bit timing counts baud ticks, not clocks: with one tick every second clock, each bit lasts 32 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| cfg_len | input | 4 | Data bits per character (5..8) |
| cfg_par | input | 5 | One-hot parity mode |
| cfg_stop2 | input | 1 | Long stop period |
| cfg_bad_par | input | 1 | Invert the parity bit |
| cfg_bad_stop | input | 1 | Drive the stop period low |
| cfg_brk_en | input | 1 | Append a break to each character |
| cfg_brk_len | input | 16 | Break length in bit times |
| glitch_wr | input | 1 | Load the glitch offset |
| glitch_clks | input | 24 | Glitch offset in clocks, 0 disarms |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_rnd | input | 1 | Use pseudo-random data |
| req_char | input | 8 | Supplied character |
| req_count | input | 32 | Characters in the burst |
| txd | output | 1 | Serial line |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-clock end-of-burst pulse |

## Verification
The bench predicts every line level in clocks counted from the observed falling start edge. With a tick in every clock, each bit lands 16 clocks after the previous one. The stop period takes 16, 24 or 32 clocks, and a glitch lands exactly N clocks after the edge.

Each sample is taken on the falling clock edge, at the clock offset the bench has computed. When ticks come every second clock, only the centre of each half-bit is compared, which absorbs the one-clock phase uncertainty of the first tick. `done` and `busy` are checked in the first clock after the last frame period, which is the clock in which the line returns high. The next burst character's start edge is expected one clock after that.

// File: rtl/fi_uart_pkg.sv
package fi_uart_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_BRK
   } fstate_t;

   // bit positions inside the one-hot parity selector
   localparam int PM_NONE  = 0;
   localparam int PM_ODD   = 1;
   localparam int PM_EVEN  = 2;
   localparam int PM_MARK  = 3;
   localparam int PM_SPACE = 4;
endpackage

// File: rtl/fi_uart_lfsr.sv
module fi_uart_lfsr #(
   parameter int                LFSR_W = 16,
   parameter int                OUT_W  = 8,
   parameter logic [LFSR_W-1:0] SEED   = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [OUT_W-1:0] val
);
   logic [LFSR_W-1:0] q;
   logic              fb;

   generate
      if (OUT_W > LFSR_W) begin : g_bad_w
         $error("fi_uart_lfsr: OUT_W exceeds LFSR_W");
      end
      if (LFSR_W == 16) begin : g_t16
         assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];
      end else if (LFSR_W == 8) begin : g_t8
         assign fb = q[7] ^ q[5] ^ q[4] ^ q[3];
      end else begin : g_tbad
         $error("fi_uart_lfsr: unsupported LFSR_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= SEED;
      else if (step) q <= {q[LFSR_W-2:0], fb};
   end

   assign val = q[OUT_W-1:0];
endmodule

// File: rtl/fi_uart_glitch.sv
module fi_uart_glitch #(
   parameter int GLITCH_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [GLITCH_W-1:0] wr_clks,
   input  logic                sof,
   output logic                flip
);
   logic                armed_q, run_q, flip_q;
   logic [GLITCH_W-1:0] tgt_q, cnt_q;

   generate
      if (GLITCH_W < 2) begin : g_bad_w
         $error("fi_uart_glitch: GLITCH_W too small");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         run_q   <= 1'b0;
         flip_q  <= 1'b0;
         tgt_q   <= '0;
         cnt_q   <= '0;
      end else begin
         flip_q <= 1'b0;
         if (wr) begin
            tgt_q   <= wr_clks;
            armed_q <= (wr_clks != '0);
            run_q   <= 1'b0;
         end else if (armed_q) begin
            if (sof) begin
               run_q <= 1'b1;
               cnt_q <= GLITCH_W'(1);
            end else if (run_q) begin
               if (cnt_q == tgt_q) begin
                  flip_q  <= 1'b1;
                  armed_q <= 1'b0;
                  run_q   <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   end

   assign flip = flip_q;

   // R7
   glitch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flip_q |=> !flip_q);
endmodule

// File: rtl/fi_uart_frame.sv
module fi_uart_frame
   import fi_uart_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   parameter int BRK_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic [DATA_W-1:0] data,
   input  logic [3:0]        cfg_len,
   input  logic [4:0]        cfg_par,
   input  logic              cfg_stop2,
   input  logic              cfg_bad_par,
   input  logic              cfg_bad_stop,
   input  logic              cfg_brk_en,
   input  logic [BRK_W-1:0]  cfg_brk_len,
   output logic              line,
   output logic              sof,
   output logic              fin
);
   localparam int TK_W = $clog2(2 * OVS);
   localparam int BI_W = $clog2(DATA_W);

   generate
      if (OVS < 4 || OVS % 2 != 0) begin : g_bad_ovs
         $error("fi_uart_frame: OVS must be even and at least 4");
      end
      if (DATA_W < 5 || DATA_W > 15) begin : g_bad_dw
         $error("fi_uart_frame: DATA_W out of range");
      end
   endgenerate

   fstate_t           st;
   logic [TK_W-1:0]   tk, lim, stop_lim_q;
   logic [BI_W-1:0]   bi;
   logic [DATA_W-1:0] sh, md;
   logic [3:0]        len_c, len_q;
   logic [BRK_W-1:0]  brk_q;
   logic              line_q, par_en_q, pbit_q, bad_stop_q, p_nom, bit_end, brk_go;

   always_comb begin
      if (cfg_len < 4'd5)              len_c = 4'd5;
      else if (cfg_len > 4'(DATA_W))   len_c = 4'(DATA_W);
      else                             len_c = cfg_len;
      md = data & ~({DATA_W{1'b1}} << len_c);
      if (cfg_par[PM_ODD])       p_nom = ~^md;
      else if (cfg_par[PM_EVEN]) p_nom = ^md;
      else if (cfg_par[PM_MARK]) p_nom = 1'b1;
      else                       p_nom = 1'b0;
   end

   assign lim     = (st == ST_STOP) ? stop_lim_q : TK_W'(OVS - 1);
   assign bit_end = tick && (tk == lim);
   assign brk_go  = (brk_q != '0);
   assign sof     = (st == ST_IDLE) && start;
   assign fin     = bit_end && ((st == ST_STOP) || (st == ST_BRK)) && !brk_go;
   assign line    = line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         line_q     <= 1'b1;
         tk         <= '0;
         bi         <= '0;
         sh         <= '0;
         len_q      <= 4'd5;
         stop_lim_q <= TK_W'(OVS - 1);
         brk_q      <= '0;
         par_en_q   <= 1'b0;
         pbit_q     <= 1'b0;
         bad_stop_q <= 1'b0;
      end else begin
         if (st != ST_IDLE && tick) tk <= bit_end ? '0 : tk + 1'b1;
         unique case (st)
            ST_IDLE: if (start) begin
               st         <= ST_START;
               line_q     <= 1'b0;
               tk         <= '0;
               sh         <= md;
               len_q      <= len_c;
               par_en_q   <= !cfg_par[PM_NONE];
               pbit_q     <= p_nom ^ cfg_bad_par;
               bad_stop_q <= cfg_bad_stop;
               brk_q      <= cfg_brk_en ? cfg_brk_len : '0;
               stop_lim_q <= !cfg_stop2 ? TK_W'(OVS - 1) :
                             (len_c == 4'd5) ? TK_W'(OVS + OVS / 2 - 1) : TK_W'(2 * OVS - 1);
            end
            ST_START: if (bit_end) begin
               st     <= ST_DATA;
               bi     <= '0;
               line_q <= sh[0];
            end
            ST_DATA: if (bit_end) begin
               sh <= sh >> 1;
               if (4'(bi) == len_q - 4'd1) begin
                  st     <= par_en_q ? ST_PAR : ST_STOP;
                  line_q <= par_en_q ? pbit_q : !bad_stop_q;
               end else begin
                  bi     <= bi + 1'b1;
                  line_q <= sh[1];
               end
            end
            ST_PAR: if (bit_end) begin
               st     <= ST_STOP;
               line_q <= !bad_stop_q;
            end
            ST_STOP: if (bit_end) begin
               if (brk_go) begin
                  st     <= ST_BRK;
                  line_q <= 1'b0;
                  brk_q  <= brk_q - 1'b1;
               end else begin
                  st     <= ST_IDLE;
                  line_q <= 1'b1;
               end
            end
            ST_BRK: if (bit_end) begin
               if (brk_go) brk_q <= brk_q - 1'b1;
               else begin
                  st     <= ST_IDLE;
                  line_q <= 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> !line_q);
   // R3
   par_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sof |-> $onehot(cfg_par));
endmodule

// File: rtl/fi_uart_tx.sv
module fi_uart_tx #(
   parameter int                DATA_W    = 8,
   parameter int                OVS       = 16,
   parameter int                GLITCH_W  = 24,
   parameter int                BRK_W     = 16,
   parameter int                CNT_W     = 32,
   parameter int                LFSR_W    = 16,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                baud_tick,
   input  logic [3:0]          cfg_len,
   input  logic [4:0]          cfg_par,
   input  logic                cfg_stop2,
   input  logic                cfg_bad_par,
   input  logic                cfg_bad_stop,
   input  logic                cfg_brk_en,
   input  logic [BRK_W-1:0]    cfg_brk_len,
   input  logic                glitch_wr,
   input  logic [GLITCH_W-1:0] glitch_clks,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_rnd,
   input  logic [DATA_W-1:0]   req_char,
   input  logic [CNT_W-1:0]    req_count,
   output logic                txd,
   output logic                busy,
   output logic                done
);
   logic              busy_q, done_q, launch_q, rnd_q;
   logic [DATA_W-1:0] chr_q, rnd_val, ch_data;
   logic [CNT_W-1:0]  left_q;
   logic              line, sof, fin, flip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         launch_q <= 1'b0;
         rnd_q    <= 1'b0;
         chr_q    <= '0;
         left_q   <= '0;
      end else begin
         done_q   <= 1'b0;
         launch_q <= 1'b0;
         if (req_valid && !busy_q) begin
            busy_q   <= 1'b1;
            launch_q <= 1'b1;
            rnd_q    <= req_rnd;
            chr_q    <= req_char;
            left_q   <= (req_count == '0) ? CNT_W'(1) : req_count;
         end else if (fin) begin
            if (left_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               left_q   <= left_q - 1'b1;
               launch_q <= 1'b1;
            end
         end
      end
   end

   assign ch_data = rnd_q ? rnd_val : chr_q;

   fi_uart_lfsr #(.LFSR_W(LFSR_W), .OUT_W(DATA_W), .SEED(LFSR_SEED)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .step(launch_q && rnd_q), .val(rnd_val)
   );

   fi_uart_frame #(.DATA_W(DATA_W), .OVS(OVS), .BRK_W(BRK_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(launch_q), .data(ch_data),
      .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
      .cfg_bad_par(cfg_bad_par), .cfg_bad_stop(cfg_bad_stop),
      .cfg_brk_en(cfg_brk_en), .cfg_brk_len(cfg_brk_len),
      .line(line), .sof(sof), .fin(fin)
   );

   fi_uart_glitch #(.GLITCH_W(GLITCH_W)) u_glitch (
      .clk(clk), .rst_n(rst_n), .wr(glitch_wr), .wr_clks(glitch_clks),
      .sof(sof), .flip(flip)
   );

   assign txd       = line ^ flip;
   assign busy      = busy_q;
   assign done      = done_q;
   assign req_ready = !busy_q;

   // R9
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy_q);
   // R11
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!busy_q && $past(busy_q)));
endmodule

// File: tb/fi_uart_tx_bench.sv
`timescale 1ns/1ps
module fi_uart_tx_bench;
   logic        clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b1;
   logic [3:0]  cfg_len = 4'd8;
   logic [4:0]  cfg_par = 5'b00001;
   logic        cfg_stop2 = 1'b0, cfg_bad_par = 1'b0, cfg_bad_stop = 1'b0, cfg_brk_en = 1'b0;
   logic [15:0] cfg_brk_len = '0;
   logic        glitch_wr = 1'b0;
   logic [23:0] glitch_clks = '0;
   logic        req_valid = 1'b0, req_rnd = 1'b0;
   logic [7:0]  req_char = '0;
   logic [31:0] req_count = '0;
   logic        req_ready, txd, busy, done;

   int          n_vec = 0, n_bad = 0, tick_div = 1;
   bit          finished = 1'b0;
   logic [15:0] lfsr_m = 16'hACE1;

   always #2 clk = ~clk;

   initial forever begin
      @(negedge clk);
      baud_tick = (tick_div == 1) ? 1'b1 : ~baud_tick;
   end

   fi_uart_tx u_fi_uart_tx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_len(cfg_len), .cfg_par(cfg_par),
      .cfg_stop2(cfg_stop2), .cfg_bad_par(cfg_bad_par), .cfg_bad_stop(cfg_bad_stop),
      .cfg_brk_en(cfg_brk_en), .cfg_brk_len(cfg_brk_len), .glitch_wr(glitch_wr),
      .glitch_clks(glitch_clks), .req_valid(req_valid), .req_ready(req_ready),
      .req_rnd(req_rnd), .req_char(req_char), .req_count(req_count),
      .txd(txd), .busy(busy), .done(done)
   );

   function automatic logic [15:0] lfsr_step(input logic [15:0] q);
      return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
   endfunction

   function automatic int eff_len(input int l);
      return (l < 5) ? 5 : (l > 8) ? 8 : l;
   endfunction

   task automatic report(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // wait for a start edge, then compare every predicted line level
   task automatic check_char(input logic [7:0] d, input int len_raw, input int pm,
                             input bit s2, input bit bp, input bit bs, input int brk,
                             input bit last, input int gl, input int dv, input string tag);
      bit          lv[0:95];
      int          nu = 0, w = 0, bad_j = -1, len;
      logic [7:0]  md;
      bit          p, e;
      logic        ba = 1'b0, be = 1'b0;
      len = eff_len(len_raw);
      md  = d & 8'((1 << len) - 1);
      lv[nu++] = 1'b0; lv[nu++] = 1'b0;
      for (int i = 0; i < len; i++) begin lv[nu++] = md[i]; lv[nu++] = md[i]; end
      if (pm != 0) begin
         case (pm)
            1: p = ~^md;
            2: p = ^md;
            3: p = 1'b1;
            default: p = 1'b0;
         endcase
         p = p ^ bp;
         lv[nu++] = p; lv[nu++] = p;
      end
      for (int i = 0; i < (!s2 ? 2 : (len == 5) ? 3 : 4); i++) lv[nu++] = !bs;
      for (int i = 0; i < 2 * brk; i++) lv[nu++] = 1'b0;
      while (txd !== 1'b0 && w < 20000) begin @(negedge clk); w++; end
      if (w >= 20000) begin
         report(1'b0, tag, "no start edge", 32'(txd), 0);
         return;
      end
      for (int j = 0; j < nu * 8 * dv; j++) begin
         if (j > 0) @(negedge clk);
         e = lv[j / (8 * dv)];
         if (dv == 1 && gl != 0 && j == gl) e = ~e;
         if ((dv == 1 || (j % (8 * dv)) == 4 * dv) && txd !== e && bad_j < 0) begin
            bad_j = j; ba = txd; be = e;
         end
      end
      report(bad_j < 0, tag, $sformatf("line at clock %0d of frame", bad_j), 32'(ba), 32'(be));
      @(negedge clk);
      report(txd === 1'b1, tag, "line high after frame", 32'(txd), 1);
      if (dv == 1)
         report(done === last && busy === !last, "R11", "done,busy after frame",
                {30'd0, done, busy}, {30'd0, last, !last});
   endtask

   task automatic send(input bit rnd, input logic [7:0] ch, input int cnt);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_rnd = rnd; req_char = ch; req_count = cnt;
      @(negedge clk);
      req_valid = 1'b0;
      report(req_ready === 1'b0 && busy === 1'b1, "R9", "ready/busy after accept",
             {30'd0, req_ready, busy}, 32'd1);
   endtask

   task automatic run_burst(input bit rnd, input logic [7:0] ch, input int cnt,
                            input int gl, input string tag);
      int         n, pm;
      logic [7:0] d;
      pm = 0;
      for (int i = 0; i < 5; i++) if (cfg_par[i]) pm = i;
      send(rnd, ch, cnt);
      n = (cnt == 0) ? 1 : cnt;
      for (int i = 0; i < n; i++) begin
         d = rnd ? lfsr_m[7:0] : ch;
         if (rnd) lfsr_m = lfsr_step(lfsr_m);
         check_char(d, int'(cfg_len), pm, cfg_stop2, cfg_bad_par, cfg_bad_stop,
                    cfg_brk_en ? int'(cfg_brk_len) : 0, i == n - 1, (i == 0) ? gl : 0,
                    tick_div, tag);
      end
   endtask

   task automatic set_cfg(input int len, input int pm, input bit s2, input bit bp,
                          input bit bs, input bit be, input int bl);
      cfg_len = 4'(len); cfg_par = 5'(1 << pm); cfg_stop2 = s2;
      cfg_bad_par = bp; cfg_bad_stop = bs; cfg_brk_en = be; cfg_brk_len = 16'(bl);
   endtask

   task automatic arm_glitch(input int n);
      @(negedge clk);
      glitch_wr = 1'b1; glitch_clks = 24'(n);
      @(negedge clk);
      glitch_wr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         report(1'b0, "R9", "watchdog expired", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned sd;
      sd = $urandom(32'd2718);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      report(txd === 1'b1, "R1", "idle line", 32'(txd), 1);
      report(busy === 1'b0 && req_ready === 1'b1 && done === 1'b0, "R1", "idle flags",
             {29'd0, busy, req_ready, done}, 32'd2);

      // R2 plain 8-bit frame and length clamping
      set_cfg(8, 0, 0, 0, 0, 0, 0); run_burst(0, 8'hA5, 1, 0, "R2");
      set_cfg(3, 0, 0, 0, 0, 0, 0); run_burst(0, 8'h3C, 1, 0, "R2");
      set_cfg(12, 0, 0, 0, 0, 0, 0); run_burst(0, 8'hC3, 1, 0, "R2");
      // R3 parity modes, R4 stop lengths
      set_cfg(5, 1, 1, 0, 0, 0, 0); run_burst(0, 8'h13, 1, 0, "R4");
      set_cfg(7, 2, 1, 0, 0, 0, 0); run_burst(0, 8'h55, 1, 0, "R4");
      set_cfg(8, 1, 0, 0, 0, 0, 0); run_burst(0, 8'h07, 1, 0, "R3");
      set_cfg(6, 3, 0, 0, 0, 0, 0); run_burst(0, 8'h00, 1, 0, "R3");
      set_cfg(6, 4, 0, 0, 0, 0, 0); run_burst(0, 8'hFF, 1, 0, "R3");
      // R5 wrong parity, and no effect without parity
      set_cfg(8, 2, 0, 1, 0, 0, 0); run_burst(0, 8'h81, 1, 0, "R5");
      set_cfg(8, 0, 0, 1, 0, 0, 0); run_burst(0, 8'h81, 1, 0, "R5");
      // R6 low stop
      set_cfg(8, 0, 1, 0, 1, 0, 0); run_burst(0, 8'h5A, 1, 0, "R6");
      // R8 break, and enable with zero length
      set_cfg(8, 1, 0, 0, 0, 1, 2); run_burst(0, 8'h99, 1, 0, "R8");
      set_cfg(8, 1, 0, 0, 0, 1, 0); run_burst(0, 8'h99, 1, 0, "R8");
      // R7 glitch fires once, then disarms; zero write disarms
      set_cfg(8, 0, 0, 0, 0, 0, 0);
      arm_glitch(37); run_burst(0, 8'hF0, 1, 37, "R7");
      run_burst(0, 8'hF0, 1, 0, "R7");
      arm_glitch(1); run_burst(0, 8'h0F, 1, 1, "R7");
      arm_glitch(50); arm_glitch(0); run_burst(0, 8'h0F, 1, 0, "R7");
      // R9 count zero, supplied burst; R10 random burst
      run_burst(0, 8'h6D, 0, 0, "R9");
      run_burst(0, 8'h6D, 3, 0, "R9");
      set_cfg(7, 2, 0, 0, 0, 0, 0); run_burst(1, 8'h00, 3, 0, "R10");
      // R12 mid-character change applies at the next start edge
      set_cfg(8, 0, 0, 0, 0, 0, 0);
      send(0, 8'h96, 1);
      fork
         check_char(8'h96, 8, 0, 0, 0, 0, 0, 1'b1, 0, 1, "R12");
         begin repeat (40) @(negedge clk); set_cfg(5, 2, 0, 0, 0, 0, 0); end
      join
      run_burst(0, 8'h96, 1, 0, "R12");
      // R13 tick every second clock
      tick_div = 2;
      set_cfg(8, 1, 0, 0, 0, 0, 0); run_burst(0, 8'hB4, 1, 0, "R13");
      tick_div = 1;
      repeat (4) @(negedge clk);

      // constrained random mix
      for (int it = 0; it < 20; it++) begin
         int bl;
         bl = ($urandom % 3 == 0) ? int'(1 + $urandom % 3) : 0;
         set_cfg(int'(5 + $urandom % 4), int'($urandom % 5), 1'($urandom), 1'($urandom),
                 ($urandom % 4 == 0), (bl != 0) || 1'($urandom), bl);
         run_burst(1'($urandom), 8'($urandom), int'(1 + $urandom % 3), 0, "R2");
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule